// File: doc/BRIEF.md
# Packed Lane Saturating Signed Adder

This block adds two 128-bit operands as a packed vector of signed integers. Every lane is summed on its own. A lane whose true sum falls outside the signed range of the lane width is clamped to that range instead of wrapping. The lane width is chosen per operation from 8, 16, 32 or 64 bits. A width select picks either the full 128-bit vector or only its low half. A scalar mode works on element 0 alone. Result bits above the processed region always come out as zero.

The result is registered one cycle after a valid strobe. A sticky saturation flag records whether any processed lane has clamped since the last clear. The control sequencing is a three-state machine. **ST_IDLE** holds the last result. **ST_DONE** presents a freshly written result for one cycle. **ST_REJECT** flags a reserved mode for one cycle. On every clock edge the next state is chosen as follows. The transition *accept* goes to ST_DONE on a legal valid strobe. The transition *reject* goes to ST_REJECT on a reserved strobe. The transition *rest* goes to ST_IDLE when there is no strobe. Any state may take any of these transitions on the next edge.

Top module: `sat_vec_adder`

## Requirements
- R1: Each lane adds only its own operand elements, and no carry crosses a lane boundary. For example, bytes 0xFF + 0x01 in every 8-bit lane give all-zero lanes.
- R2: On signed overflow in a lane, the result is the most negative value of the lane width when the first operand element is negative, and the most positive value otherwise.
- R3: A lane without overflow returns the two's-complement sum of its elements.
- R4: `size_i` selects the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lane e occupies bits [e*W +: W].
- R5: With `wide_i` = 1 all 128 bits are processed. With `wide_i` = 0 only bits [63:0] are processed, and result bits [127:64] are zero.
- R6: With `scalar_i` = 1 only element 0 is processed, at any size and whatever the value of `wide_i`. All result bits above element 0 are zero.
- R7: `sat_flag_o` becomes 1 after a legal operation in which any processed lane clamps. It stays 1 through later operations that do not clamp.
- R8: Lanes outside the processed region never set `sat_flag_o`, even when their inputs would overflow.
- R9: `clr_sat_i` makes `sat_flag_o` 0 at the next edge. If the same edge also accepts a clamping operation, the flag ends as 1.
- R10: `result_o` and `done_o` update at the edge that samples `valid_i`. `done_o` is high for exactly that following cycle. Without a strobe, `result_o` holds its value.
- R11: A vector operation (`scalar_i` = 0) with `wide_i` = 0 and `size_i` = 3 is reserved. It raises `illegal_o` for one cycle, leaves `done_o` low and changes neither `result_o` nor `sat_flag_o`.
- R12: After reset, `result_o` is 0 and `sat_flag_o`, `done_o` and `illegal_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Lane width select |
| wide_i | input | 1 | 1 = full 128-bit vector, 0 = low 64 bits |
| scalar_i | input | 1 | Process element 0 only |
| clr_sat_i | input | 1 | Clear the sticky saturation flag |
| opa_i | input | 128 | First operand |
| opb_i | input | 128 | Second operand |
| result_o | output | 128 | Registered result |
| sat_flag_o | output | 1 | Sticky saturation flag |
| done_o | output | 1 | Result written in the previous edge |
| illegal_o | output | 1 | Reserved mode rejected in the previous edge |

## Verification
A table of mixed operands covers every lane width in the full, half and scalar modes. Each result is compared with a behavioural per-lane model, which separates correct lane slicing from misrouted size selection. Directed cases cover the following:
- Sums sitting exactly on the positive and negative limits, which tell clamping direction apart from wrapping.
- All-ones plus one in every lane, which exposes any carry leaking between lanes.
- Overflowing inputs placed only in inactive lanes, which show whether the flag and upper bits are masked.
- Flag sequences (sticky hold, lone clear, clear alongside a clamp) and a reserved-mode strobe, which show that nothing is written when the mode is rejected.

// File: rtl/sat_add_pkg.sv
package sat_add_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } lane_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DONE   = 2'd1,
        ST_REJECT = 2'd2
    } ctl_state_e;

    // Lane width in bits for a size code, given the narrowest lane.
    function automatic int unsigned lane_bits(input logic [1:0] sz, input int unsigned min_w);
        return min_w << sz;
    endfunction

endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         ovf;

    always_comb begin
        raw = a_i + b_i;
        ovf = (a_i[W-1] == b_i[W-1]) && (raw[W-1] != a_i[W-1]);
        if (ovf) begin
            y_o = a_i[W-1] ? NEG_LIM : POS_LIM;
        end else begin
            y_o = raw;
        end
        sat_o = ovf;
    end
endmodule

// File: rtl/sat_lane_array.sv
module sat_lane_array #(
    parameter int unsigned VEC_W  = 128,
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned ACT_B  = 8
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic [ACT_B-1:0] act_w_i,
    output logic [VEC_W-1:0] y_o,
    output logic             sat_any_o
);
    localparam int unsigned LANES = VEC_W / ELEM_W;

    logic [LANES-1:0] lane_sat;
    logic [LANES-1:0] lane_en;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        sat_lane #(.W(ELEM_W)) i_lane (
            .a_i   (a_i[j*ELEM_W +: ELEM_W]),
            .b_i   (b_i[j*ELEM_W +: ELEM_W]),
            .y_o   (y_o[j*ELEM_W +: ELEM_W]),
            .sat_o (lane_sat[j])
        );
        assign lane_en[j] = (ACT_B'(j * ELEM_W) < act_w_i);
    end

    assign sat_any_o = |(lane_sat & lane_en);
endmodule

// File: rtl/sat_vec_adder.sv
module sat_vec_adder
    import sat_add_pkg::*;
#(
    parameter int unsigned VEC_W      = 128,
    parameter int unsigned MIN_ELEM_W = 8,
    parameter int unsigned NUM_SIZES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [1:0]       size_i,
    input  logic             wide_i,
    input  logic             scalar_i,
    input  logic             clr_sat_i,
    input  logic [VEC_W-1:0] opa_i,
    input  logic [VEC_W-1:0] opb_i,
    output logic [VEC_W-1:0] result_o,
    output logic             sat_flag_o,
    output logic             done_o,
    output logic             illegal_o
);
    localparam int unsigned HALF_W = VEC_W / 2;
    localparam int unsigned ACT_B  = $clog2(VEC_W) + 1;

    logic [VEC_W-1:0] sum_by_sz [NUM_SIZES];
    logic [NUM_SIZES-1:0] sat_by_sz;
    logic [ACT_B-1:0] act_w;
    logic [VEC_W-1:0] keep_mask;
    logic [VEC_W-1:0] sum_sel;
    logic             sat_sel;
    logic             reserved;
    logic             accept;
    ctl_state_e       state_q, state_d;

    // Active width in bits for this request.
    always_comb begin
        if (scalar_i) begin
            act_w = ACT_B'(lane_bits(size_i, MIN_ELEM_W));
        end else if (wide_i) begin
            act_w = ACT_B'(VEC_W);
        end else begin
            act_w = ACT_B'(HALF_W);
        end
    end

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        sat_lane_array #(
            .VEC_W  (VEC_W),
            .ELEM_W (MIN_ELEM_W << s),
            .ACT_B  (ACT_B)
        ) i_arr (
            .a_i       (opa_i),
            .b_i       (opb_i),
            .act_w_i   (act_w),
            .y_o       (sum_by_sz[s]),
            .sat_any_o (sat_by_sz[s])
        );
    end

    always_comb begin
        for (int k = 0; k < VEC_W; k++) begin
            keep_mask[k] = (ACT_B'(k) < act_w);
        end
        sum_sel  = sum_by_sz[size_i] & keep_mask;
        sat_sel  = sat_by_sz[size_i];
        reserved = !scalar_i && !wide_i && (size_i == SZ_D);
        accept   = valid_i && !reserved;
    end

    // Next-state selection.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_REJECT: begin
                if (valid_i && reserved) begin
                    state_d = ST_REJECT;
                end else if (valid_i) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        done_o    = (state_q == ST_DONE);
        illegal_o = (state_q == ST_REJECT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
        end else if (accept) begin
            result_o <= sum_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sat_flag_o <= 1'b0;
        end else if (clr_sat_i) begin
            sat_flag_o <= accept && sat_sel;
        end else if (accept && sat_sel) begin
            sat_flag_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sat_vec_adder_chk.sv
module sat_vec_adder_chk #(
    parameter int unsigned VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [1:0]       size_i,
    input logic             wide_i,
    input logic             scalar_i,
    input logic             clr_sat_i,
    input logic [VEC_W-1:0] result_o,
    input logic             sat_flag_o,
    input logic             done_o,
    input logic             illegal_o
);
    localparam int unsigned HALF_W = VEC_W / 2;

    logic rsv;
    assign rsv = !scalar_i && !wide_i && (size_i == 2'd3);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag_o && !clr_sat_i) |=> sat_flag_o);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sat_i && !valid_i) |=> !sat_flag_o);

    p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && rsv) |=> (illegal_o && !done_o && $stable(result_o)));

    p_reject_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && rsv && !clr_sat_i) |=> $stable(sat_flag_o));

    p_half_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !scalar_i && !wide_i && !rsv) |=> (result_o[VEC_W-1:HALF_W] == '0));

    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !rsv) |=> done_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!done_o && !illegal_o && $stable(result_o)));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, illegal_o}));
endmodule

bind sat_vec_adder sat_vec_adder_chk #(.VEC_W(VEC_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .size_i     (size_i),
    .wide_i     (wide_i),
    .scalar_i   (scalar_i),
    .clr_sat_i  (clr_sat_i),
    .result_o   (result_o),
    .sat_flag_o (sat_flag_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o)
);

// File: tb/test_sat_vec_adder.sv
`timescale 1ns/1ps
module test_sat_vec_adder;

    typedef struct packed {
        logic [1:0]   sz;
        logic         wide;
        logic         scl;
        logic [127:0] a;
        logic [127:0] b;
    } stim_t;

    localparam int NSTIM = 9;
    localparam stim_t STIM [NSTIM] = '{
        '{2'd0, 1'b1, 1'b0, 128'h7F80_01FF_4040_C0C0_1234_5678_9ABC_DEF0, 128'h0180_FF01_4041_BFBF_0102_0304_0506_0708},
        '{2'd1, 1'b1, 1'b0, 128'h7FFF_8000_1234_F000_4000_C000_0001_FFFF, 128'h0001_FFFF_4321_F000_4000_C000_7FFE_FFFF},
        '{2'd2, 1'b1, 1'b0, 128'h7FFF_FFF0_8000_0005_0000_0001_C000_0000, 128'h0000_0020_FFFF_FFF0_7FFF_FFFE_C000_0000},
        '{2'd3, 1'b1, 1'b0, 128'h4000_0000_0000_0000_8000_0000_0000_0010, 128'h4000_0000_0000_0000_FFFF_FFFF_FFFF_FFE0},
        '{2'd0, 1'b0, 1'b0, 128'h7F7F_7F7F_7F7F_7F7F_8081_7F00_6050_A0B0, 128'h7F7F_7F7F_7F7F_7F7F_8080_0100_2030_D0C0},
        '{2'd2, 1'b0, 1'b0, 128'h1111_2222_3333_4444_8000_0000_7000_0000, 128'h5555_6666_7777_8888_8000_0000_1000_0000},
        '{2'd1, 1'b0, 1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_7FFF_8000, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0001_8000},
        '{2'd3, 1'b0, 1'b1, 128'h7FFF_FFFF_FFFF_FFFF_0000_0000_1234_5678, 128'h7FFF_FFFF_FFFF_FFFF_0000_0000_1111_1111},
        '{2'd2, 1'b1, 1'b1, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_8000_0001, 128'h5555_5555_5555_5555_5555_5555_8000_0001}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         valid_i;
    logic [1:0]   size_i;
    logic         wide_i;
    logic         scalar_i;
    logic         clr_sat_i;
    logic [127:0] opa_i;
    logic [127:0] opb_i;
    logic [127:0] result_o;
    logic         sat_flag_o;
    logic         done_o;
    logic         illegal_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sat_vec_adder i_sat_vec_adder (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .size_i     (size_i),
        .wide_i     (wide_i),
        .scalar_i   (scalar_i),
        .clr_sat_i  (clr_sat_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .result_o   (result_o),
        .sat_flag_o (sat_flag_o),
        .done_o     (done_o),
        .illegal_o  (illegal_o)
    );

    // Behavioural per-lane model: {saturated, result}.
    function automatic logic [128:0] model(input logic [1:0] sz, input logic wide,
                                           input logic scl, input logic [127:0] a,
                                           input logic [127:0] b);
        int w;
        int act;
        logic [127:0] y;
        logic sat;
        logic signed [64:0] ea, eb, s, mx, mn;
        w   = 8 << sz;
        act = scl ? w : (wide ? 128 : 64);
        y   = '0;
        sat = 1'b0;
        for (int e = 0; e < act / w; e++) begin
            for (int k = 0; k < 65; k++) begin
                ea[k] = (k < w) ? a[e*w+k] : a[e*w+w-1];
                eb[k] = (k < w) ? b[e*w+k] : b[e*w+w-1];
            end
            s  = ea + eb;
            mx = (65'sd1 <<< (w - 1)) - 65'sd1;
            mn = -(65'sd1 <<< (w - 1));
            if (s > mx) begin
                s = mx; sat = 1'b1;
            end else if (s < mn) begin
                s = mn; sat = 1'b1;
            end
            for (int k = 0; k < 64; k++) begin
                if (k < w) y[e*w+k] = s[k];
            end
        end
        return {sat, y};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one strobe; outputs are sampled on the following falling edge.
    task automatic op(input logic [1:0] sz, input logic wide, input logic scl,
                      input logic clr, input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        valid_i = 1'b1; size_i = sz; wide_i = wide; scalar_i = scl;
        clr_sat_i = clr; opa_i = a; opb_i = b;
        @(negedge clk);
        valid_i = 1'b0; clr_sat_i = 1'b0;
    endtask

    task automatic idle_cycle(input logic clr);
        @(negedge clk);
        valid_i = 1'b0; clr_sat_i = clr;
        @(negedge clk);
        clr_sat_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [128:0] m;
        logic [127:0] held;
        rst_n = 1'b0; valid_i = 1'b0; size_i = 2'd0; wide_i = 1'b0;
        scalar_i = 1'b0; clr_sat_i = 1'b0; opa_i = '0; opb_i = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 result", result_o, '0);
        chk("R12 flags", {125'd0, sat_flag_o, done_o, illegal_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk (R3, R4, R5, R6): clear with each op so flag equals this op's saturation.
        for (int i = 0; i < NSTIM; i++) begin
            m = model(STIM[i].sz, STIM[i].wide, STIM[i].scl, STIM[i].a, STIM[i].b);
            op(STIM[i].sz, STIM[i].wide, STIM[i].scl, 1'b1, STIM[i].a, STIM[i].b);
            chk($sformatf("R4 table[%0d] result", i), result_o, m[127:0]);
            chk($sformatf("R7 table[%0d] flag", i), {127'd0, sat_flag_o}, {127'd0, m[128]});
            chk($sformatf("R10 table[%0d] done", i), {127'd0, done_o}, 128'd1);
        end

        // R1: all-ones plus one in every byte lane, no carry leakage.
        op(2'd0, 1'b1, 1'b0, 1'b1, {16{8'hFF}}, {16{8'h01}});
        chk("R1 carry isolation", result_o, '0);
        chk("R1 no sat", {127'd0, sat_flag_o}, '0);

        // R2: byte lanes at both limits.
        op(2'd0, 1'b1, 1'b0, 1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_807F,
                                   128'h0000_0000_0000_0000_0000_0000_0000_FF01);
        chk("R2 byte clamp", result_o, 128'h0000_0000_0000_0000_0000_0000_0000_807F);
        chk("R2 byte sat flag", {127'd0, sat_flag_o}, 128'd1);

        // R2: 64-bit lanes at both limits.
        op(2'd3, 1'b1, 1'b0, 1'b1, 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF,
                                   128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0001);
        chk("R2 dword clamp", result_o, 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF);

        // R3: exact limit reached without overflow.
        op(2'd1, 1'b1, 1'b0, 1'b1, 128'h0000_0000_0000_0000_0000_0000_C000_7FFE,
                                   128'h0000_0000_0000_0000_0000_0000_C000_0001);
        chk("R3 on-limit sum", result_o, 128'h0000_0000_0000_0000_0000_0000_8000_7FFF);
        chk("R3 no sat", {127'd0, sat_flag_o}, '0);

        // R5 and R8: upper half overflows but is inactive.
        op(2'd0, 1'b0, 1'b0, 1'b1, {{8{8'h7F}}, 64'h0102_0304_0506_0708},
                                   {{8{8'h7F}}, 64'h0101_0101_0101_0101});
        chk("R5 half result", result_o, {64'd0, 64'h0203_0405_0607_0809});
        chk("R8 half no sat", {127'd0, sat_flag_o}, '0);

        // R6: scalar clamps element 0; Q ignored.
        op(2'd1, 1'b1, 1'b1, 1'b1, {8{16'h7FFF}}, {8{16'h0001}});
        chk("R6 scalar result", result_o, 128'h0000_0000_0000_0000_0000_0000_0000_7FFF);
        chk("R6 scalar sat", {127'd0, sat_flag_o}, 128'd1);

        // R8: scalar with only element 1 overflowing.
        op(2'd1, 1'b1, 1'b1, 1'b1, 128'h7FFF_0005, 128'h7FFF_0006);
        chk("R8 scalar result", result_o, 128'h0000_000B);
        chk("R8 scalar no sat", {127'd0, sat_flag_o}, '0);

        // R7: sticky across a non-saturating op.
        op(2'd0, 1'b1, 1'b0, 1'b0, 128'h7F, 128'h7F);
        chk("R7 set", {127'd0, sat_flag_o}, 128'd1);
        op(2'd0, 1'b1, 1'b0, 1'b0, 128'h01, 128'h02);
        chk("R7 sticky", {127'd0, sat_flag_o}, 128'd1);
        chk("R7 result", result_o, 128'h03);

        // R9: lone clear, then clear with a clamping op.
        idle_cycle(1'b1);
        chk("R9 clear", {127'd0, sat_flag_o}, '0);
        op(2'd2, 1'b1, 1'b0, 1'b1, 128'h8000_0000, 128'h8000_0000);
        chk("R9 clear+sat", {127'd0, sat_flag_o}, 128'd1);
        chk("R9 result", result_o, 128'h8000_0000);
        idle_cycle(1'b1);

        // R10: one-cycle done, result held without strobe.
        op(2'd0, 1'b1, 1'b0, 1'b0, 128'h10, 128'h20);
        held = result_o;
        chk("R10 done", {127'd0, done_o}, 128'd1);
        @(negedge clk);
        chk("R10 done drops", {127'd0, done_o}, '0);
        chk("R10 hold", result_o, held);

        // R11: reserved mode with overflowing inputs.
        op(2'd3, 1'b0, 1'b0, 1'b0, {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h7FFF_FFFF_FFFF_FFFF}});
        chk("R11 illegal", {126'd0, illegal_o, done_o}, 128'd2);
        chk("R11 no write", result_o, held);
        chk("R11 no flag", {127'd0, sat_flag_o}, '0);
        @(negedge clk);
        chk("R11 pulse", {127'd0, illegal_o}, '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule